// File: doc/BRIEF.md
# Paired-Page TLB Lookup Checker

This block translates a virtual address through a two-part translation buffer and reports whether the access is allowed. Every entry covers two neighbouring pages, an even one and an odd one, and holds a separate attribute word for each half. The first part is a set-indexed array of `WAYS` ways by `2**SET_BITS` sets, all sharing one page size that is supplied on a configuration pin. The second part is a small fully associative array whose entries each carry their own page size. The set-indexed part is always consulted first. The associative part only supplies the result when the set-indexed part has no hit.

A lookup is offered on a valid/ready request channel carrying the virtual address, the address-space identifier, the current privilege level and the access kind. One clock later a response appears on a valid/ready channel with a 3-bit result code, the physical address and three permission bits. The response register is the only storage on the path. The request channel is ready whenever that register is empty or is being drained in the same cycle (`req_ready = !rsp_valid || rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, the response holds still and no new request is taken.

Entries are filled through a plain write port. This port takes an entry index, a tag word and two attribute words. The page size pin and the 32-bit mode pin are plain control inputs that are sampled together with each accepted request.

Top module: `paired_tlb`

## Requirements
- R1: The set-indexed part is searched at set `(va >> (cfg_ps+1)) mod 2**SET_BITS` in all ways, and the lowest hitting way is used. The associative part is used only when no way hits, and within it the lowest hitting slot is used.
- R2: An entry hits only if its exists bit is set and its stored tag (virtual address bits from 13 upward) equals `va[VA_W-1:13]` in every bit at position `ps-12` and above. Tag bits below that position are ignored. `ps` is `cfg_ps` for the set-indexed part and the entry's own page size for the associative part.
- R3: An entry also needs either its global flag to be set (bit 4 of the even attribute word) or its stored identifier to equal `req_asid`.
- R4: `va[ps]` chooses the odd attribute word (`wr_hi`) when it is 1 and the even word (`wr_lo`) when it is 0.
- R5: The result codes are 0 match, 1 no hit, 2 invalid, 3 execute-inhibit, 4 read-inhibit, 5 privilege, 6 modify. The first one that applies is reported, in this order: valid bit 0 clear gives 2; a fetch (`req_acc`=0) with no-execute bit 6 set gives 3; a load (`req_acc`=1) with no-read bit 7 set gives 4; a privilege fault gives 5; a store (`req_acc`=2) with dirty bit 1 clear gives 6.
- R6: The privilege rule uses bit 5 of the attribute word. When that bit is 0, a fault occurs if `req_plv` is numerically greater than the entry level in bits 3:2. When it is 1, a fault occurs if `req_plv` differs from the entry level.
- R7: On a match, the frame number is taken from attribute bits `PA_W-1:12`, and its bits below `ps-12` are cleared. `rsp_pa` is that frame number shifted left by 12, ORed with the low `ps` bits of the virtual address.
- R8: `rsp_perm` bit 0 (read) is set on every match. Bit 1 (write) equals the dirty bit. Bit 2 (execute) is the inverse of the no-execute bit. For any result other than a match, `rsp_pa` and `rsp_perm` are zero.
- R9: While `mode32` is high, the no-execute, no-read and restricted-privilege bits are treated as 0.
- R10: An address that hits in neither part returns code 1.
- R11: The response is valid on the clock after a request is accepted. It holds unchanged while `rsp_ready` is low, and `req_ready` follows the rule given above.
- R12: A write with index below `WAYS*2**SET_BITS` fills set `idx mod 2**SET_BITS`, way `idx / 2**SET_BITS`. Higher indices fill associative slot `idx - WAYS*2**SET_BITS`. The tag word packs exists in bit 0, the identifier above it, then the page size, then the tag in the top bits. A lookup accepted in the same cycle as a write sees the contents from before the write.
- R13: Reset clears every exists bit and `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ps | input | PS_W | Page size (log2) of the set-indexed part |
| mode32 | input | 1 | 32-bit mode: ignore no-execute, no-read and restricted-privilege bits |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high with req_valid |
| req_va | input | VA_W | Virtual address |
| req_asid | input | ASID_W | Current address-space identifier |
| req_plv | input | 2 | Current privilege level |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_code | output | 3 | Result code |
| rsp_pa | output | PA_W | Physical address |
| rsp_perm | output | 3 | Permission bits {execute, write, read} |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry index |
| wr_misc | input | MISC_W | Tag word {tag, page size, identifier, exists} |
| wr_lo | input | PA_W | Even-page attribute word |
| wr_hi | input | PA_W | Odd-page attribute word |

## Verification
The bench builds the block with 32-bit virtual and physical addresses, 16 sets, 2 ways and 4 associative slots. At that size the index arithmetic is easy to reason about, and two ways sharing a set and a tag can be loaded to show lowest-way priority. With the shared page size set to 4 KiB, the set-indexed part compares every tag bit. An associative entry with a 16 KiB page has two ignored tag bits and two cleared frame bits. This pairing exercises both the masking and the fallback order between the parts. A second associative entry alias of a set-indexed page shows the set part winning, and shows the fallback taking over when the identifier check removes the set hit.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

  typedef enum logic [2:0] {
    RC_MATCH   = 3'd0,
    RC_NOMATCH = 3'd1,
    RC_INVALID = 3'd2,
    RC_NOEXEC  = 3'd3,
    RC_NOREAD  = 3'd4,
    RC_PRIV    = 3'd5,
    RC_MODIFY  = 3'd6
  } rc_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  // attribute word bit positions
  localparam int A_VALID  = 0;
  localparam int A_DIRTY  = 1;
  localparam int A_PLV_LO = 2;
  localparam int A_GLOBAL = 4;
  localparam int A_RPLV   = 5;
  localparam int A_NX     = 6;
  localparam int A_NR     = 7;
  localparam int A_FRAME  = 12;

  // permission bit positions
  localparam int P_READ  = 0;
  localparam int P_WRITE = 1;
  localparam int P_EXEC  = 2;

  // tag field starts at this address bit
  localparam int TAG_LSB = 13;

endpackage

// File: rtl/ptlb_tag_cmp.sv
module ptlb_tag_cmp #(
  parameter int VA_W   = 48,
  parameter int ASID_W = 10,
  parameter int PS_W   = 6,
  localparam int TAG_W = VA_W - ptlb_pkg::TAG_LSB
) (
  input  logic [VA_W-1:0]   va,
  input  logic [PS_W-1:0]   ps,
  input  logic              exists,
  input  logic              glb,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [TAG_W-1:0]  tag,
  output logic              hit
);
  logic [PS_W-1:0]  drop;
  logic [TAG_W-1:0] keep_mask;
  logic [TAG_W-1:0] diff;
  logic             asid_ok;

  // tag bits below (ps+1-13) belong to the pair/page offset
  assign drop      = ps - PS_W'(12);
  assign keep_mask = {TAG_W{1'b1}} << drop;
  assign diff      = (va[VA_W-1:ptlb_pkg::TAG_LSB] ^ tag) & keep_mask;
  assign asid_ok   = glb || (ent_asid == cur_asid);
  assign hit       = exists && asid_ok && (diff == '0);
endmodule

// File: rtl/ptlb_set_array.sv
module ptlb_set_array #(
  parameter int VA_W     = 48,
  parameter int PA_W     = 48,
  parameter int ASID_W   = 10,
  parameter int PS_W     = 6,
  parameter int SET_BITS = 8,
  parameter int WAYS     = 8,
  localparam int SETS  = 1 << SET_BITS,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W = VA_W - ptlb_pkg::TAG_LSB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WAY_W-1:0]    wr_way,
  input  logic [SET_BITS-1:0] wr_set,
  input  logic                wr_ex,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [PA_W-1:0]     wr_lo,
  input  logic [PA_W-1:0]     wr_hi,
  input  logic [VA_W-1:0]     va,
  input  logic [ASID_W-1:0]   asid,
  input  logic [PS_W-1:0]     ps,
  output logic                hit,
  output logic [PA_W-1:0]     lo,
  output logic [PA_W-1:0]     hi
);
  logic              ex_q   [WAYS][SETS];
  logic [ASID_W-1:0] asid_q [WAYS][SETS];
  logic [TAG_W-1:0]  tag_q  [WAYS][SETS];
  logic [PA_W-1:0]   lo_q   [WAYS][SETS];
  logic [PA_W-1:0]   hi_q   [WAYS][SETS];

  logic [VA_W-1:0]     vpn;
  logic [SET_BITS-1:0] set_idx;
  logic [WAYS-1:0]     way_hit;
  logic [PA_W-1:0]     way_lo [WAYS];
  logic [PA_W-1:0]     way_hi [WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++)
          ex_q[w][s] <= 1'b0;
    end else if (wr_en) begin
      ex_q[wr_way][wr_set] <= wr_ex;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      asid_q[wr_way][wr_set] <= wr_asid;
      tag_q[wr_way][wr_set]  <= wr_tag;
      lo_q[wr_way][wr_set]   <= wr_lo;
      hi_q[wr_way][wr_set]   <= wr_hi;
    end
  end

  assign vpn     = va >> (ps + PS_W'(1));
  assign set_idx = vpn[SET_BITS-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_lo[w] = lo_q[w][set_idx];
    assign way_hi[w] = hi_q[w][set_idx];
    ptlb_tag_cmp #(.VA_W(VA_W), .ASID_W(ASID_W), .PS_W(PS_W)) u_cmp (
      .va       (va),
      .ps       (ps),
      .exists   (ex_q[w][set_idx]),
      .glb      (lo_q[w][set_idx][ptlb_pkg::A_GLOBAL]),
      .ent_asid (asid_q[w][set_idx]),
      .cur_asid (asid),
      .tag      (tag_q[w][set_idx]),
      .hit      (way_hit[w])
    );
  end

  // lowest way wins
  always_comb begin
    hit = 1'b0;
    lo  = '0;
    hi  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        hit = 1'b1;
        lo  = way_lo[w];
        hi  = way_hi[w];
      end
    end
  end
endmodule

// File: rtl/ptlb_assoc_array.sv
module ptlb_assoc_array #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 48,
  parameter int ASID_W  = 10,
  parameter int PS_W    = 6,
  parameter int N_ASSOC = 8,
  localparam int SLOT_W = (N_ASSOC > 1) ? $clog2(N_ASSOC) : 1,
  localparam int TAG_W  = VA_W - ptlb_pkg::TAG_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_ex,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PS_W-1:0]   wr_ps,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [PA_W-1:0]   wr_lo,
  input  logic [PA_W-1:0]   wr_hi,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  output logic              hit,
  output logic [PS_W-1:0]   ps,
  output logic [PA_W-1:0]   lo,
  output logic [PA_W-1:0]   hi
);
  logic              ex_q   [N_ASSOC];
  logic [ASID_W-1:0] asid_q [N_ASSOC];
  logic [PS_W-1:0]   ps_q   [N_ASSOC];
  logic [TAG_W-1:0]  tag_q  [N_ASSOC];
  logic [PA_W-1:0]   lo_q   [N_ASSOC];
  logic [PA_W-1:0]   hi_q   [N_ASSOC];
  logic [N_ASSOC-1:0] slot_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ASSOC; i++) ex_q[i] <= 1'b0;
    end else if (wr_en) begin
      ex_q[wr_slot] <= wr_ex;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      asid_q[wr_slot] <= wr_asid;
      ps_q[wr_slot]   <= wr_ps;
      tag_q[wr_slot]  <= wr_tag;
      lo_q[wr_slot]   <= wr_lo;
      hi_q[wr_slot]   <= wr_hi;
    end
  end

  for (genvar i = 0; i < N_ASSOC; i++) begin : g_slot
    ptlb_tag_cmp #(.VA_W(VA_W), .ASID_W(ASID_W), .PS_W(PS_W)) u_cmp (
      .va       (va),
      .ps       (ps_q[i]),
      .exists   (ex_q[i]),
      .glb      (lo_q[i][ptlb_pkg::A_GLOBAL]),
      .ent_asid (asid_q[i]),
      .cur_asid (asid),
      .tag      (tag_q[i]),
      .hit      (slot_hit[i])
    );
  end

  // lowest slot wins
  always_comb begin
    hit = 1'b0;
    ps  = '0;
    lo  = '0;
    hi  = '0;
    for (int i = N_ASSOC - 1; i >= 0; i--) begin
      if (slot_hit[i]) begin
        hit = 1'b1;
        ps  = ps_q[i];
        lo  = lo_q[i];
        hi  = hi_q[i];
      end
    end
  end
endmodule

// File: rtl/ptlb_perm.sv
module ptlb_perm
  import ptlb_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48,
  parameter int PS_W = 6,
  localparam int FRAME_W = PA_W - A_FRAME
) (
  input  logic            hit,
  input  logic [PA_W-1:0] ent,
  input  logic [VA_W-1:0] va,
  input  logic [PS_W-1:0] ps,
  input  logic [1:0]      acc,
  input  logic [1:0]      plv,
  input  logic            mode32,
  output logic [2:0]      code,
  output logic [PA_W-1:0] pa,
  output logic [2:0]      perm
);
  logic               nx, nr, rplv, priv_bad;
  logic [1:0]         ent_plv;
  logic [FRAME_W-1:0] frame, frame_clr;
  logic [PA_W-1:0]    off_mask;
  logic [PA_W-1:0]    va_t;
  rc_e                rc;

  assign nx       = ent[A_NX]   & ~mode32;
  assign nr       = ent[A_NR]   & ~mode32;
  assign rplv     = ent[A_RPLV] & ~mode32;
  assign ent_plv  = ent[A_PLV_LO +: 2];
  assign priv_bad = rplv ? (plv != ent_plv) : (plv > ent_plv);

  always_comb begin
    if (!hit)                                rc = RC_NOMATCH;
    else if (!ent[A_VALID])                  rc = RC_INVALID;
    else if (acc == ACC_FETCH && nx)         rc = RC_NOEXEC;
    else if (acc == ACC_LOAD && nr)          rc = RC_NOREAD;
    else if (priv_bad)                       rc = RC_PRIV;
    else if (acc == ACC_STORE && !ent[A_DIRTY]) rc = RC_MODIFY;
    else                                     rc = RC_MATCH;
  end

  assign frame     = ent[PA_W-1:A_FRAME];
  assign frame_clr = frame & ({FRAME_W{1'b1}} << (ps - PS_W'(12)));
  assign off_mask  = ~({PA_W{1'b1}} << ps);
  assign va_t      = PA_W'(va);

  always_comb begin
    code = rc;
    pa   = '0;
    perm = '0;
    if (rc == RC_MATCH) begin
      pa           = {frame_clr, {A_FRAME{1'b0}}} | (va_t & off_mask);
      perm[P_READ] = 1'b1;
      perm[P_WRITE]= ent[A_DIRTY];
      perm[P_EXEC] = ~nx;
    end
  end
endmodule

// File: rtl/paired_tlb.sv
module paired_tlb
  import ptlb_pkg::*;
#(
  parameter int VA_W     = 48,
  parameter int PA_W     = 48,
  parameter int ASID_W   = 10,
  parameter int PS_W     = 6,
  parameter int SET_BITS = 8,
  parameter int WAYS     = 8,
  parameter int N_ASSOC  = 8,
  localparam int SET_TOT = (1 << SET_BITS) * WAYS,
  localparam int IDX_W   = $clog2(SET_TOT + N_ASSOC),
  localparam int TAG_W   = VA_W - TAG_LSB,
  localparam int MISC_W  = 1 + ASID_W + PS_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PS_W-1:0]   cfg_ps,
  input  logic              mode32,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [1:0]        req_plv,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_code,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [2:0]        rsp_perm,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [MISC_W-1:0] wr_misc,
  input  logic [PA_W-1:0]   wr_lo,
  input  logic [PA_W-1:0]   wr_hi
);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int SLOT_W = (N_ASSOC > 1) ? $clog2(N_ASSOC) : 1;

  // write decode
  logic              w_ex;
  logic [ASID_W-1:0] w_asid;
  logic [PS_W-1:0]   w_ps;
  logic [TAG_W-1:0]  w_tag;
  logic              w_to_set, w_to_assoc;
  logic [IDX_W-1:0]  w_rel;

  assign w_ex   = wr_misc[0];
  assign w_asid = wr_misc[ASID_W:1];
  assign w_ps   = wr_misc[ASID_W+PS_W:ASID_W+1];
  assign w_tag  = wr_misc[MISC_W-1:ASID_W+PS_W+1];

  assign w_to_set   = wr_en && (int'(wr_idx) < SET_TOT);
  assign w_rel      = wr_idx - IDX_W'(SET_TOT);
  assign w_to_assoc = wr_en && !(int'(wr_idx) < SET_TOT) && (int'(w_rel) < N_ASSOC);

  // lookup
  logic            s_hit, a_hit, any_hit;
  logic [PA_W-1:0] s_lo, s_hi, a_lo, a_hi, sel_lo, sel_hi, ent;
  logic [PS_W-1:0] a_ps, use_ps;
  logic [2:0]      c_code, c_perm;
  logic [PA_W-1:0] c_pa;

  ptlb_set_array #(
    .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .PS_W(PS_W),
    .SET_BITS(SET_BITS), .WAYS(WAYS)
  ) u_set (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (w_to_set),
    .wr_way  (WAY_W'(wr_idx >> SET_BITS)),
    .wr_set  (wr_idx[SET_BITS-1:0]),
    .wr_ex   (w_ex),
    .wr_asid (w_asid),
    .wr_tag  (w_tag),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .va      (req_va),
    .asid    (req_asid),
    .ps      (cfg_ps),
    .hit     (s_hit),
    .lo      (s_lo),
    .hi      (s_hi)
  );

  ptlb_assoc_array #(
    .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .PS_W(PS_W), .N_ASSOC(N_ASSOC)
  ) u_assoc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (w_to_assoc),
    .wr_slot (SLOT_W'(w_rel)),
    .wr_ex   (w_ex),
    .wr_asid (w_asid),
    .wr_ps   (w_ps),
    .wr_tag  (w_tag),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .va      (req_va),
    .asid    (req_asid),
    .hit     (a_hit),
    .ps      (a_ps),
    .lo      (a_lo),
    .hi      (a_hi)
  );

  // set-indexed part takes precedence
  assign any_hit = s_hit || a_hit;
  assign use_ps  = s_hit ? cfg_ps : a_ps;
  assign sel_lo  = s_hit ? s_lo : a_lo;
  assign sel_hi  = s_hit ? s_hi : a_hi;
  assign ent     = req_va[use_ps] ? sel_hi : sel_lo;

  ptlb_perm #(.VA_W(VA_W), .PA_W(PA_W), .PS_W(PS_W)) u_perm (
    .hit    (any_hit),
    .ent    (ent),
    .va     (req_va),
    .ps     (use_ps),
    .acc    (req_acc),
    .plv    (req_plv),
    .mode32 (mode32),
    .code   (c_code),
    .pa     (c_pa),
    .perm   (c_perm)
  );

  // response register
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RC_NOMATCH;
      rsp_pa    <= '0;
      rsp_perm  <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_code <= c_code;
        rsp_pa   <= c_pa;
        rsp_perm <= c_perm;
      end
    end
  end

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) &&
                                   $stable(rsp_pa) && $stable(rsp_perm)));

  // R11
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R8
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != RC_MATCH) |-> (rsp_pa == '0 && rsp_perm == '0));

  // R8
  match_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RC_MATCH) |-> rsp_perm[P_READ]);

  // R5
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code <= 3'd6));
endmodule

// File: tb/tb_paired_tlb.sv
`timescale 1ns/1ps
module tb_paired_tlb;
  localparam int VA_W = 32, PA_W = 32, ASID_W = 10, PS_W = 6;
  localparam int SET_BITS = 4, WAYS = 2, N_ASSOC = 4;
  localparam int IDX_W = 6, MISC_W = 36;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [PS_W-1:0]   cfg_ps = 6'd12;
  logic              mode32 = 1'b0;
  logic              req_valid = 1'b0, req_ready;
  logic [VA_W-1:0]   req_va = '0;
  logic [ASID_W-1:0] req_asid = '0;
  logic [1:0]        req_plv = '0, req_acc = '0;
  logic              rsp_valid, rsp_ready = 1'b1;
  logic [2:0]        rsp_code, rsp_perm;
  logic [PA_W-1:0]   rsp_pa;
  logic              wr_en = 1'b0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic [MISC_W-1:0] wr_misc = '0;
  logic [PA_W-1:0]   wr_lo = '0, wr_hi = '0;

  paired_tlb #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .PS_W(PS_W),
               .SET_BITS(SET_BITS), .WAYS(WAYS), .N_ASSOC(N_ASSOC)) dut (.*);

  int n_chk = 0, n_bad = 0;

  function automatic logic [MISC_W-1:0] mk_misc(logic e, logic [9:0] asid,
                                                logic [5:0] ps, logic [18:0] tag);
    return {tag, ps, asid, e};
  endfunction

  function automatic logic [PA_W-1:0] mk_ent(logic v, logic d, logic [1:0] plv,
      logic g, logic rp, logic nx, logic nr, logic [19:0] frame);
    return {frame, 4'b0, nr, nx, rp, g, plv, d, v};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [MISC_W-1:0] m, logic [PA_W-1:0] lo, logic [PA_W-1:0] hi);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_misc = m; wr_lo = lo; wr_hi = hi;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(logic [31:0] va, logic [9:0] asid, logic [1:0] plv,
                      logic [1:0] acc, logic m32);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_asid = asid; req_plv = plv;
    req_acc = acc; mode32 = m32; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_rsp(string req, logic [2:0] code, logic [31:0] pa, logic [2:0] perm);
    chk({req, " valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " code"}, 32'(rsp_code), 32'(code));
    chk({req, " pa"}, rsp_pa, pa);
    chk({req, " perm"}, 32'(rsp_perm), 32'(perm));
  endtask

  // {va, asid, plv, acc, m32, code, pa, perm}; acc 0 fetch 1 load 2 store
  localparam int VW = 85;
  localparam int NV = 19;
  localparam logic [VW-1:0] VEC [NV] = '{
    {32'h0000_2123, 10'd5, 2'd3, 2'd1, 1'b0, 3'd0, 32'h0010_0123, 3'd7},
    {32'h0000_3456, 10'd5, 2'd3, 2'd1, 1'b0, 3'd5, 32'h0, 3'd0},
    {32'h0000_3456, 10'd5, 2'd3, 2'd2, 1'b0, 3'd5, 32'h0, 3'd0},
    {32'h0000_3456, 10'd5, 2'd0, 2'd2, 1'b0, 3'd6, 32'h0, 3'd0},
    {32'h0000_3456, 10'd5, 2'd0, 2'd1, 1'b0, 3'd0, 32'h0020_0456, 3'd5},
    {32'h0000_2123, 10'd6, 2'd3, 2'd1, 1'b0, 3'd0, 32'h0077_7123, 3'd7},
    {32'h0002_2010, 10'd0, 2'd0, 2'd1, 1'b0, 3'd2, 32'h0, 3'd0},
    {32'h0002_3010, 10'd0, 2'd3, 2'd0, 1'b0, 3'd3, 32'h0, 3'd0},
    {32'h0002_3010, 10'd0, 2'd3, 2'd1, 1'b0, 3'd0, 32'h0030_0010, 3'd3},
    {32'h0002_3010, 10'd0, 2'd3, 2'd0, 1'b1, 3'd0, 32'h0030_0010, 3'd7},
    {32'h0000_4000, 10'd5, 2'd1, 2'd1, 1'b0, 3'd4, 32'h0, 3'd0},
    {32'h0000_4000, 10'd5, 2'd1, 2'd2, 1'b0, 3'd0, 32'h0040_0000, 3'd7},
    {32'h0000_4000, 10'd5, 2'd0, 2'd2, 1'b0, 3'd5, 32'h0, 3'd0},
    {32'h0000_4000, 10'd5, 2'd0, 2'd1, 1'b1, 3'd0, 32'h0040_0000, 3'd7},
    {32'h0000_4000, 10'd7, 2'd1, 2'd1, 1'b0, 3'd1, 32'h0, 3'd0},
    {32'h0010_1ABC, 10'd3, 2'd0, 2'd1, 1'b0, 3'd0, 32'h0123_5ABC, 3'd7},
    {32'h0010_6004, 10'd3, 2'd1, 2'd1, 1'b0, 3'd0, 32'h0200_2004, 3'd5},
    {32'h0010_8000, 10'd3, 2'd0, 2'd1, 1'b0, 3'd1, 32'h0, 3'd0},
    {32'h0000_6010, 10'd0, 2'd0, 2'd1, 1'b0, 3'd0, 32'h00A0_0010, 3'd7}
  };
  // requirement exercised by each row
  localparam string VTAG [NV] = '{
    "R4 R7", "R6", "R5", "R5", "R4 R8", "R1 R3", "R5", "R5", "R8", "R9",
    "R5", "R6", "R6", "R9", "R3 R10", "R2 R7", "R4 R7", "R2 R10", "R1"
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13: reset state
    chk("R13 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R11 req_ready", 32'(req_ready), 32'd1);
    look(32'h0000_2123, 10'd5, 2'd3, 2'd1, 1'b0);
    chk_rsp("R13 empty", 3'd1, 32'h0, 3'd0);

    // R12: write and lookup in the same cycle see old contents
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd1; wr_misc = mk_misc(1, 10'd5, 6'd0, 19'h1);
    wr_lo = mk_ent(1, 1, 2'd3, 0, 0, 0, 0, 20'h100);
    wr_hi = mk_ent(1, 0, 2'd0, 0, 0, 0, 0, 20'h200);
    req_valid = 1'b1; req_va = 32'h0000_2123; req_asid = 10'd5; req_plv = 2'd3; req_acc = 2'd1;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk_rsp("R12 old", 3'd1, 32'h0, 3'd0);
    look(32'h0000_2123, 10'd5, 2'd3, 2'd1, 1'b0);
    chk_rsp("R12 new", 3'd0, 32'h0010_0123, 3'd7);

    // remaining entries
    wr(17, mk_misc(1, 10'd9, 6'd0, 19'h11), mk_ent(0, 0, 2'd0, 1, 0, 0, 0, 20'h0),
                                          mk_ent(1, 1, 2'd3, 0, 0, 1, 0, 20'h300));
    wr(2,  mk_misc(1, 10'd5, 6'd0, 19'h2),  mk_ent(1, 1, 2'd1, 0, 1, 0, 1, 20'h400),
                                          mk_ent(1, 1, 2'd2, 0, 1, 0, 0, 20'h500));
    wr(32, mk_misc(1, 10'd0, 6'd14, 19'h81), mk_ent(1, 1, 2'd3, 1, 0, 0, 0, 20'h1237),
                                           mk_ent(1, 0, 2'd3, 1, 0, 0, 0, 20'h2000));
    wr(33, mk_misc(1, 10'd0, 6'd12, 19'h1), mk_ent(1, 1, 2'd3, 1, 0, 0, 0, 20'h777),
                                          mk_ent(1, 1, 2'd3, 1, 0, 0, 0, 20'h778));
    wr(3,  mk_misc(1, 10'd0, 6'd0, 19'h3),  mk_ent(1, 1, 2'd3, 1, 0, 0, 0, 20'hA00),
                                          mk_ent(1, 1, 2'd3, 1, 0, 0, 0, 20'hA01));
    wr(19, mk_misc(1, 10'd0, 6'd0, 19'h3),  mk_ent(1, 1, 2'd3, 1, 0, 0, 0, 20'hB00),
                                          mk_ent(1, 1, 2'd3, 1, 0, 0, 0, 20'hB01));

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      look(v[84:53], v[52:43], v[42:41], v[40:39], v[38]);
      chk_rsp(VTAG[i], v[37:35], v[34:3], v[2:0]);
    end

    // R11: back-pressure holds the response and stalls requests
    @(negedge clk);
    rsp_ready = 1'b0; mode32 = 1'b0;
    req_valid = 1'b1; req_va = 32'h0000_2123; req_asid = 10'd5; req_plv = 2'd3; req_acc = 2'd1;
    @(negedge clk);
    chk("R11 stall ready", 32'(req_ready), 32'd0);
    req_va = 32'h0000_6010; req_asid = 10'd0; req_plv = 2'd0;
    @(negedge clk);
    chk_rsp("R11 held", 3'd0, 32'h0010_0123, 3'd7);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk_rsp("R11 next", 3'd0, 32'h00A0_0010, 3'd7);

    // R13: reset empties both parts
    rst_n = 1'b0;
    @(negedge clk);
    chk("R13 rsp_valid again", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    look(32'h0000_2123, 10'd6, 2'd3, 2'd1, 1'b0);
    chk_rsp("R13 cleared", 3'd1, 32'h0, 3'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule